// File: doc/BRIEF.md
# Prescaled Pseudo-Random Clock Generator

This block makes a pseudo-random bit stream, used as a spread-spectrum clock, from a single system clock. A power-of-two prescaler divides the clock by a ratio picked with a three-bit code, or it can be bypassed so that every cycle counts. The prescaler does not make a derived clock. It issues a one-cycle step enable, and only on that enable does a linear feedback shift register advance. Two shift registers, 8 and 12 bits long, run side by side. A width bit chooses which most significant bit becomes the generated bit, and an enable bit forces that bit to zero.

A single 8-bit control register holds all settings and can be written and read back. The pin output either passes a default signal through unchanged, or it carries the generated bit, uninverted or complemented. Everything runs in the one clock domain.

Top module: `prs_clkgen`

## Requirements
- R1: With bypass clear, `step_o` is a single-cycle pulse every N cycles, where N = 2 << code (code 0 gives 2, code 7 gives 256). After reset with the register at 0x00, the first pulse comes in the second cycle.
- R2: With bypass set, `step_o` is high on every cycle and the divide code has no effect.
- R3: While enabled, each shift register moves only in a cycle where `step_o` is high. The next state is `{s[W-2:0], fb}`, where fb is the XOR of the tap bits: bits 7,5,4,3 for the 8-bit register (x^8+x^6+x^5+x^4+1) and bits 11,5,3,0 for the 12-bit register (x^12+x^6+x^4+x+1). Each register holds its seed of 1 after reset and while disabled.
- R4: With the enable bit clear, `prs_o` is 0 and both shift registers reload their seed.
- R5: With the enable bit set, `prs_o` is bit 7 of the 8-bit register when the width bit is 0, and bit 11 of the 12-bit register when the width bit is 1.
- R6: With the route bit set, `pin_o` equals `prs_o` XOR the invert bit.
- R7: With the route bit clear, `pin_o` equals `dflt_pin`.
- R8: The control register resets to 0x00 and loads `ctrl_wdata` at an edge where `ctrl_we` is high. `ctrl_rdata` shows the stored value from the next cycle on. Field positions: bit 7 route, bit 6 invert, bit 5 width, bit 4 enable, bit 3 bypass, bits 2:0 divide code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register contents |
| dflt_pin | input | 1 | Signal passed to the pin when not routed |
| step_o | output | 1 | Prescaler step enable |
| prs_o | output | 1 | Generated pseudo-random bit |
| pin_o | output | 1 | Pin output |

## Verification
Every cycle, the assertions check that a divided step is never followed directly by another one, that a shift register holds still without a step and is never all zero, that a disabled register sits at its seed, that the generated bit stays put while nothing could move it, and that a write lands in the register. The exact divide ratio for each code, the tap sequences, the choice of width, the inversion and the default-pin pass-through can only be shown by the bench. It compares every output on every cycle with a model built from the requirements, under random register writes and under directed cases for the longest divider, bypass, and switching the enable.

// File: rtl/prs_clkgen_pkg.sv
package prs_clkgen_pkg;
   localparam int CODE_W = 3;

   typedef struct packed {
      logic              route;
      logic              invert;
      logic              wide;
      logic              prs_en;
      logic              bypass;
      logic [CODE_W-1:0] code;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass,
   input  logic [CODE_W-1:0] code,
   output logic              step
);
   localparam int CNT_W = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
      $error("prs_prescaler: CODE_W must lie in 1..4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   ratio;
   logic [CNT_W-1:0] term;

   always_comb begin
      ratio = (CNT_W+1)'(2) << code;
      term  = CNT_W'(ratio - 1'b1);
   end

   assign step = bypass | (cnt_q == term);

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (bypass || cnt_q >= term)  cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
   end

   // R1: a divided step never repeats in the next cycle unless bypass is on
   p_step_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !bypass) |=> (!step || bypass));
endmodule

// File: rtl/prs_lfsr.sv
module prs_lfsr #(
   parameter int             W    = 8,
   parameter logic [W-1:0]   TAPS = 8'hB8,
   parameter logic [W-1:0]   SEED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         step,
   output logic [W-1:0] state
);
   if (W < 3) begin : g_bad_w
      $error("prs_lfsr: W must be at least 3");
   end
   if (!TAPS[W-1]) begin : g_bad_taps
      $error("prs_lfsr: top tap must be set");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("prs_lfsr: seed must be nonzero");
   end

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) state <= SEED;
      else if (step)     state <= {state[W-2:0], fb};
   end

   // R3: no step, no movement
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !step) |=> $stable(state));
   // R3: the lock-up state is never entered
   p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
   // R4: disabled means seeded
   p_seeded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == SEED);
endmodule

// File: rtl/prs_clkgen.sv
module prs_clkgen
   import prs_clkgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   input  logic              dflt_pin,
   output logic              step_o,
   output logic              prs_o,
   output logic              pin_o
);
   localparam int          NARROW_W = 8;
   localparam int          WIDE_W   = 12;
   localparam logic [NARROW_W-1:0] NARROW_TAPS = 8'hB8;
   localparam logic [WIDE_W-1:0]   WIDE_TAPS   = 12'h829;

   ctrl_t ctrl_q;
   logic [NARROW_W-1:0] narrow_s;
   logic [WIDE_W-1:0]   wide_s;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
   end
   assign ctrl_rdata = ctrl_q;

   prs_prescaler #(.CODE_W(CODE_W)) presc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bypass (ctrl_q.bypass),
      .code   (ctrl_q.code),
      .step   (step_o)
   );

   prs_lfsr #(.W(NARROW_W), .TAPS(NARROW_TAPS), .SEED(NARROW_W'(1))) lfsr_n_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q.prs_en),
      .step  (step_o),
      .state (narrow_s)
   );

   prs_lfsr #(.W(WIDE_W), .TAPS(WIDE_TAPS), .SEED(WIDE_W'(1))) lfsr_w_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q.prs_en),
      .step  (step_o),
      .state (wide_s)
   );

   always_comb begin
      if (!ctrl_q.prs_en)    prs_o = 1'b0;
      else if (ctrl_q.wide)  prs_o = wide_s[WIDE_W-1];
      else                   prs_o = narrow_s[NARROW_W-1];
   end

   assign pin_o = ctrl_q.route ? (prs_o ^ ctrl_q.invert) : dflt_pin;

   // R8: a write is visible in the next cycle
   p_ctrl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> ctrl_rdata == $past(ctrl_wdata));
   // R5: without a step or a write the generated bit cannot change
   p_prs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_o && !ctrl_we) |=> $stable(prs_o));
endmodule

// File: tb/prs_clkgen_tb_top.sv
module prs_clkgen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic [7:0] ctrl_rdata;
   logic       dflt_pin = 1'b0;
   logic       step_o, prs_o, pin_o;

   int errors = 0;
   int checks = 0;
   bit checking = 1'b0;

   always #4 clk = ~clk;

   prs_clkgen dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .dflt_pin(dflt_pin), .step_o(step_o),
      .prs_o(prs_o), .pin_o(pin_o)
   );

   // model state built from the requirements
   logic [7:0]  m_ctrl;
   logic [7:0]  m_cnt;
   logic [7:0]  m_l8;
   logic [11:0] m_l12;

   function automatic logic [7:0] term_of(input logic [2:0] code);
      return 8'((9'd2 << code) - 9'd1);
   endfunction

   function automatic logic exp_step(input logic [7:0] c, input logic [7:0] cnt);
      return c[3] | (cnt == term_of(c[2:0]));
   endfunction

   function automatic logic exp_prs(input logic [7:0] c, input logic [7:0] l8,
                                    input logic [11:0] l12);
      if (!c[4]) return 1'b0;
      return c[5] ? l12[11] : l8[7];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl <= '0; m_cnt <= '0; m_l8 <= 8'd1; m_l12 <= 12'd1;
      end else begin
         if (ctrl_we) m_ctrl <= ctrl_wdata;
         if (m_ctrl[3] || m_cnt >= term_of(m_ctrl[2:0])) m_cnt <= '0;
         else m_cnt <= m_cnt + 8'd1;
         if (!m_ctrl[4]) begin
            m_l8 <= 8'd1; m_l12 <= 12'd1;
         end else if (exp_step(m_ctrl, m_cnt)) begin
            m_l8  <= {m_l8[6:0],  ^(m_l8 & 8'hB8)};
            m_l12 <= {m_l12[10:0], ^(m_l12 & 12'h829)};
         end
      end
   end

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison at the falling edge; inputs move 1 ns later
   always @(negedge clk) begin
      if (checking && rst_n) begin
         logic ep;
         ep = exp_prs(m_ctrl, m_l8, m_l12);
         chk("R8 rdata", 12'(ctrl_rdata), 12'(m_ctrl));
         chk(m_ctrl[3] ? "R2 step" : "R1 step", 12'(step_o), 12'(exp_step(m_ctrl, m_cnt)));
         chk(m_ctrl[4] ? "R5 prs (R3 sequence)" : "R4 prs", 12'(prs_o), 12'(ep));
         chk(m_ctrl[7] ? "R6 pin" : "R7 pin", 12'(pin_o),
             12'(m_ctrl[7] ? (ep ^ m_ctrl[6]) : dflt_pin));
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         dflt_pin = 1'($urandom);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk); #1;
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); #1;
      ctrl_we = 1'b0; ctrl_wdata = 8'($urandom);
   endtask

   task automatic period_check(input logic [2:0] code);
      int t0, t1;
      wr({5'b00000, code});
      @(posedge step_o); t0 = int'($time);
      @(posedge step_o); t1 = int'($time);
      chk("R1 period", 12'((t1 - t0) / 8), 12'(2 << code));
   endtask

   initial begin
      void'($urandom(32'd1234));
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset value", 12'(ctrl_rdata), 12'h00);
      checking = 1'b1;
      // R1 directed ratios at each end and in the middle
      period_check(3'd0);
      period_check(3'd3);
      period_check(3'd7);
      // R2 bypass ignores the code
      wr(8'h0F); tick(20);
      // R3/R5 both widths, routed and inverted
      wr(8'hD8); tick(300);
      wr(8'hF8); tick(300);
      wr(8'hB1); tick(400);
      // R4 disable then re-enable
      wr(8'h80); tick(10);
      wr(8'h90); tick(60);
      // R7 default path
      wr(8'h18); tick(30);
      // random mix
      for (int k = 0; k < 60; k++) begin
         wr(8'($urandom));
         tick(int'($urandom_range(20, 700)));
      end
      checking = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule